// File: doc/BRIEF.md
# Block Memory Move Engine

This block is a sequencer that copies a run of bytes from one memory region to another. It works through a single-port byte memory interface that has an address, read and write strobes, read and write data, and a ready handshake. A start request supplies five values: a source bank byte, a destination bank byte, the starting source index (X), the starting destination index (Y) and a count register (C). C holds the number of bytes minus one. A direction select chooses between stepping the indices up and stepping them down. When the destination begins above the source, the caller selects the downward variant and passes X and Y pointing at the last byte of each region. With that choice, overlapping regions are copied without corrupting any source byte before it is read.

For each byte the engine reads at `{src_bank, X}` and writes the same value at `{dst_bank, Y}`. It then steps X and Y and decrements C. The engine stops after the byte on which C wraps from zero to all ones. A one-cycle done pulse then marks the final X, Y and C on the outputs. The destination bank is reported as the new data bank. An index-width input narrows X and Y to their low byte, and in that mode their upper bits stay zero.

Top module: `blkmove_engine`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are low, and mem_addr, x_out, y_out, c_out and dbank_out are zero.
- R2: A start seen at a clock edge while idle latches all request inputs. In the next cycle mem_rd is high with mem_addr = {src_bank, X}, where bits 23:16 are the bank and bits 15:0 are the index.
- R3: Each byte is one read followed by one write. The write puts the data returned by the accepted read at {dst_bank, Y}.
- R4: With dir_dec = 0, X and Y each increase by one after every accepted write, wrapping modulo 2^16.
- R5: With dir_dec = 1, X and Y each decrease by one after every accepted write, wrapping modulo 2^16.
- R6: A move copies exactly C+1 bytes, and C = 0 copies one byte. C decreases by one per accepted write and equals 0xFFFF when done is high.
- R7: done is high for exactly one cycle, in the cycle after the final write is accepted. The engine is idle in the following cycle. x_out, y_out and c_out show the final index and count values, and dbank_out shows the destination bank.
- R8: With idx8 = 1 at start, X and Y load with their upper 8 bits cleared. They step modulo 256 in the low byte and their upper 8 bits stay zero.
- R9: While mem_ready is low, the active strobe, mem_addr and mem_wdata hold unchanged. No byte is skipped or repeated.
- R10: A start request while busy, including the cycle in which done is high, is ignored and has no effect on the move in progress.
- R11: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a move (taken only when idle) |
| dir_dec | input | 1 | 1 = step indices down, 0 = step up |
| idx8 | input | 1 | 1 = 8-bit index mode |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| x_in | input | 16 | Starting source index |
| y_in | input | 16 | Starting destination index |
| c_in | input | 16 | Byte count minus one |
| mem_addr | output | 24 | Memory byte address {bank, index} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when mem_rd and mem_ready are high |
| mem_ready | input | 1 | Memory accepts the current access |
| busy | output | 1 | A move is in progress or finishing |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current or final source index |
| y_out | output | 16 | Current or final destination index |
| c_out | output | 16 | Current or final count |
| dbank_out | output | 8 | Data bank result (destination bank) |

## Verification
Two functions can land in the same cycle: a new start request and the completion of the running move. The bench provokes this by raising start in the very cycle done is seen, and by raising start while a stalled move is still in progress. In both cases the behavioural model expects the request to be dropped, and every output is compared each clock against that model. A second collision is a memory stall on the final write, which coincides with the count wrap. Runs whose ready is low for long stretches check that the count wraps once, that done follows only the accepted write, and that the destination bytes match a snapshot of the source taken before the move.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

   typedef enum logic [1:0] {
      MV_IDLE   = 2'd0,
      MV_READ   = 2'd1,
      MV_WRITE  = 2'd2,
      MV_FINISH = 2'd3
   } mv_state_t;

endpackage

// File: rtl/blkmove_idx_step.sv
module blkmove_idx_step #(
   parameter int IDX_W      = 16,
   parameter int NARROW_W   = 8,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic [IDX_W-1:0] cur,
   input  logic             dec,
   input  logic             narrow,
   output logic [IDX_W-1:0] nxt
);

   logic [IDX_W-1:0] wide_nxt;

   assign wide_nxt = dec ? (cur - IDX_W'(1)) : (cur + IDX_W'(1));

   generate
      if (HAS_NARROW) begin : g_narrow
         logic [NARROW_W-1:0] low_nxt;
         assign low_nxt = dec ? (cur[NARROW_W-1:0] - NARROW_W'(1))
                              : (cur[NARROW_W-1:0] + NARROW_W'(1));
         assign nxt = narrow ? {{(IDX_W-NARROW_W){1'b0}}, low_nxt} : wide_nxt;
      end else begin : g_wide
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign nxt = wide_nxt;
      end
   endgenerate

endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
   import blkmove_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_ready,
   input  logic last,
   output logic ld,
   output logic cap,
   output logic step,
   output logic rd_phase,
   output logic wr_phase,
   output logic busy,
   output logic done
);

   mv_state_t st_q, st_d;

   assign rd_phase = (st_q == MV_READ);
   assign wr_phase = (st_q == MV_WRITE);
   assign ld       = (st_q == MV_IDLE) && start;
   assign cap      = rd_phase && mem_ready;
   assign step     = wr_phase && mem_ready;
   assign busy     = (st_q != MV_IDLE);
   assign done     = (st_q == MV_FINISH);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         MV_IDLE:   if (start)     st_d = MV_READ;
         MV_READ:   if (mem_ready) st_d = MV_WRITE;
         MV_WRITE:  if (mem_ready) st_d = last ? MV_FINISH : MV_READ;
         MV_FINISH: st_d = MV_IDLE;
         default:   st_d = MV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= MV_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/blkmove_dp.sv
module blkmove_dp #(
   parameter int IDX_W      = 16,
   parameter int BANK_W     = 8,
   parameter int DATA_W     = 8,
   parameter int NARROW_W   = 8,
   parameter bit HAS_NARROW = 1'b1,
   localparam int ADDR_W    = BANK_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              cap,
   input  logic              step,
   input  logic              rd_phase,
   input  logic              wr_phase,
   input  logic              dir_dec,
   input  logic              narrow_in,
   input  logic [BANK_W-1:0] src_bank,
   input  logic [BANK_W-1:0] dst_bank,
   input  logic [IDX_W-1:0]  x_in,
   input  logic [IDX_W-1:0]  y_in,
   input  logic [IDX_W-1:0]  c_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [IDX_W-1:0]  x_q,
   output logic [IDX_W-1:0]  y_q,
   output logic [IDX_W-1:0]  c_q,
   output logic [BANK_W-1:0] db_q,
   output logic              narrow_q,
   output logic              last
);

   localparam logic [IDX_W-1:0] LOW_MASK = IDX_W'((1 << NARROW_W) - 1);

   logic [BANK_W-1:0] sb_q;
   logic [DATA_W-1:0] buf_q;
   logic              dec_q;
   logic              narrow_ld;
   logic [IDX_W-1:0]  x_ld, y_ld, x_nxt, y_nxt;

   assign narrow_ld = HAS_NARROW ? narrow_in : 1'b0;
   assign x_ld      = narrow_ld ? (x_in & LOW_MASK) : x_in;
   assign y_ld      = narrow_ld ? (y_in & LOW_MASK) : y_in;
   assign last      = (c_q == '0);

   blkmove_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W), .HAS_NARROW(HAS_NARROW)) u_xstep (
      .cur(x_q), .dec(dec_q), .narrow(narrow_q), .nxt(x_nxt));

   blkmove_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W), .HAS_NARROW(HAS_NARROW)) u_ystep (
      .cur(y_q), .dec(dec_q), .narrow(narrow_q), .nxt(y_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q      <= '0;
         y_q      <= '0;
         c_q      <= '0;
         sb_q     <= '0;
         db_q     <= '0;
         dec_q    <= 1'b0;
         narrow_q <= 1'b0;
      end else if (ld) begin
         x_q      <= x_ld;
         y_q      <= y_ld;
         c_q      <= c_in;
         sb_q     <= src_bank;
         db_q     <= dst_bank;
         dec_q    <= dir_dec;
         narrow_q <= narrow_ld;
      end else if (step) begin
         x_q <= x_nxt;
         y_q <= y_nxt;
         c_q <= c_q - IDX_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   buf_q <= '0;
      else if (cap) buf_q <= mem_rdata;
   end

   always_comb begin
      if (rd_phase)      mem_addr = {sb_q, x_q};
      else if (wr_phase) mem_addr = {db_q, y_q};
      else               mem_addr = '0;
   end

   assign mem_wdata = buf_q;

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
   parameter int IDX_W      = 16,
   parameter int BANK_W     = 8,
   parameter int DATA_W     = 8,
   parameter int NARROW_W   = 8,
   parameter bit HAS_NARROW = 1'b1,
   localparam int ADDR_W    = BANK_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_dec,
   input  logic              idx8,
   input  logic [BANK_W-1:0] src_bank,
   input  logic [BANK_W-1:0] dst_bank,
   input  logic [IDX_W-1:0]  x_in,
   input  logic [IDX_W-1:0]  y_in,
   input  logic [IDX_W-1:0]  c_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  x_out,
   output logic [IDX_W-1:0]  y_out,
   output logic [IDX_W-1:0]  c_out,
   output logic [BANK_W-1:0] dbank_out
);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("blkmove_engine: IDX_W must be at least 2");
      end
      if (HAS_NARROW && (NARROW_W < 1 || NARROW_W >= IDX_W)) begin : g_bad_narrow
         $error("blkmove_engine: NARROW_W must lie between 1 and IDX_W-1");
      end
      if (BANK_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("blkmove_engine: BANK_W and DATA_W must be positive");
      end
   endgenerate

   logic ld, cap, step, last, mode8;

   blkmove_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_ready(mem_ready), .last(last),
      .ld(ld), .cap(cap), .step(step), .rd_phase(mem_rd), .wr_phase(mem_wr),
      .busy(busy), .done(done));

   blkmove_dp #(
      .IDX_W(IDX_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
      .NARROW_W(NARROW_W), .HAS_NARROW(HAS_NARROW)
   ) u_dp (
      .clk(clk), .rst_n(rst_n), .ld(ld), .cap(cap), .step(step),
      .rd_phase(mem_rd), .wr_phase(mem_wr), .dir_dec(dir_dec), .narrow_in(idx8),
      .src_bank(src_bank), .dst_bank(dst_bank), .x_in(x_in), .y_in(y_in), .c_in(c_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .x_q(x_out), .y_q(y_out), .c_q(c_out), .db_q(dbank_out),
      .narrow_q(mode8), .last(last));

endmodule

// File: rtl/blkmove_chk.sv
module blkmove_chk #(
   parameter int IDX_W    = 16,
   parameter int BANK_W   = 8,
   parameter int DATA_W   = 8,
   parameter int NARROW_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     mem_rd,
   input logic                     mem_wr,
   input logic                     mem_ready,
   input logic [BANK_W+IDX_W-1:0]  mem_addr,
   input logic [DATA_W-1:0]        mem_wdata,
   input logic [DATA_W-1:0]        mem_rdata,
   input logic                     busy,
   input logic                     done,
   input logic [IDX_W-1:0]         x_out,
   input logic [IDX_W-1:0]         y_out,
   input logic [IDX_W-1:0]         c_out,
   input logic                     mode8
);

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_write_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ready) |=> (mem_wr && mem_wdata == $past(mem_rdata)));

   p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

   p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mem_wr && mem_ready));

   p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (c_out == '1));

   p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode8 && busy) |-> (x_out[IDX_W-1:NARROW_W] == '0 && y_out[IDX_W-1:NARROW_W] == '0));

endmodule

bind blkmove_engine blkmove_chk #(
   .IDX_W(16), .BANK_W(8), .DATA_W(8), .NARROW_W(8)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
   .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .c_out(c_out), .mode8(mode8));

// File: tb/tb_blkmove_engine.sv
module tb_blkmove_engine;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, dir_dec = 1'b0, idx8 = 1'b0;
   logic [7:0]  src_bank = '0, dst_bank = '0;
   logic [15:0] x_in = '0, y_in = '0, c_in = '0;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr, mem_ready;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        busy, done;
   logic [15:0] x_out, y_out, c_out;
   logic [7:0]  dbank_out;

   int nvec = 0, nfail = 0, cycles = 0;
   int stall_mode = 0;
   int unsigned lcg = 32'h1234_5678;
   int stall_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blkmove_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec), .idx8(idx8),
      .src_bank(src_bank), .dst_bank(dst_bank), .x_in(x_in), .y_in(y_in), .c_in(c_in),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
      .x_out(x_out), .y_out(y_out), .c_out(c_out), .dbank_out(dbank_out));

   // bench memory: 4096 bytes, indexed by bank[1:0] and index[9:0]
   logic [7:0] ram [0:4095];
   function automatic int ix(logic [23:0] a);
      return int'({a[17:16], a[9:0]});
   endfunction

   assign mem_rdata = ram[ix(mem_addr)];

   initial begin
      for (int i = 0; i < 4096; i++) ram[i] = 8'(i * 37 + 11);
   end

   always @(posedge clk) begin
      if (mem_wr && mem_ready) ram[ix(mem_addr)] <= mem_wdata;
   end

   // ready pattern, changed away from the active edge
   initial mem_ready = 1'b1;
   always @(negedge clk) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      stall_cnt = stall_cnt + 1;
      if (stall_mode == 0)      mem_ready = 1'b1;
      else if (stall_mode == 1) mem_ready = lcg[16];
      else                      mem_ready = (stall_cnt % 6 == 0);
   end

   // behavioural reference model
   int          mst;          // 0 idle, 1 read, 2 write, 3 finished
   logic [15:0] mx, my, mc;
   logic [7:0]  msb, mdb, mbuf;
   logic        mdec, mn8;

   function automatic logic [15:0] stepv(logic [15:0] v, logic d, logic n);
      logic [15:0] r;
      r = d ? v - 16'd1 : v + 16'd1;
      if (n) r = {8'h00, r[7:0]};
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst = 0; mx = '0; my = '0; mc = '0; msb = '0; mdb = '0; mbuf = '0;
         mdec = 1'b0; mn8 = 1'b0;
      end else begin
         case (mst)
            0: if (start) begin
                  mn8 = idx8; mdec = dir_dec;
                  mx = idx8 ? {8'h00, x_in[7:0]} : x_in;
                  my = idx8 ? {8'h00, y_in[7:0]} : y_in;
                  mc = c_in; msb = src_bank; mdb = dst_bank;
                  mst = 1;
               end
            1: if (mem_ready) begin
                  mbuf = ram[ix({msb, mx})];
                  mst = 2;
               end
            2: if (mem_ready) begin
                  mst = (mc == 16'd0) ? 3 : 1;
                  mx = stepv(mx, mdec, mn8);
                  my = stepv(my, mdec, mn8);
                  mc = mc - 16'd1;
               end
            default: mst = 0;
         endcase
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      logic [23:0] eaddr;
      cycles++;
      eaddr = (mst == 1) ? {msb, mx} : (mst == 2) ? {mdb, my} : 24'h0;
      check("R7 busy",      32'(busy),   32'(mst != 0));
      check("R7 done",      32'(done),   32'(mst == 3));
      check("R2 mem_rd",    32'(mem_rd), 32'(mst == 1));
      check("R3 mem_wr",    32'(mem_wr), 32'(mst == 2));
      check("R2/R3 addr R9", 32'(mem_addr), 32'(eaddr));
      if (mst == 2) check("R3 wdata", 32'(mem_wdata), 32'(mbuf));
      check("R4 R5 R8 x_out", 32'(x_out), 32'(mx));
      check("R4 R5 R8 y_out", 32'(y_out), 32'(my));
      check("R6 c_out",     32'(c_out),  32'(mc));
      check("R7 dbank_out", 32'(dbank_out), 32'(mdb));
      if (cycles > WDOG_LIMIT) begin
         nfail++;
         $display("FAIL watchdog R7: actual no completion expected done by cycle %0d", WDOG_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   // request helpers
   logic [23:0] src_list [$];
   logic [23:0] dst_list [$];
   logic [7:0]  snap [$];

   task automatic launch(logic [7:0] sb, logic [7:0] db, logic [15:0] x, logic [15:0] y,
                         logic [15:0] c, logic d, logic n);
      logic [15:0] xa, ya;
      src_list.delete(); dst_list.delete(); snap.delete();
      xa = n ? {8'h00, x[7:0]} : x;
      ya = n ? {8'h00, y[7:0]} : y;
      for (int k = 0; k <= int'(c); k++) begin
         src_list.push_back({sb, xa});
         dst_list.push_back({db, ya});
         snap.push_back(ram[ix({sb, xa})]);
         xa = stepv(xa, d, n);
         ya = stepv(ya, d, n);
      end
      @(negedge clk);
      src_bank = sb; dst_bank = db; x_in = x; y_in = y; c_in = c;
      dir_dec = d; idx8 = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (done !== 1'b1 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic check_mem(string tag);
      for (int k = 0; k < snap.size(); k++)
         check(tag, 32'(ram[ix(dst_list[k])]), 32'(snap[k]));
   endtask

   task automatic finish_move(string tag);
      wait_done();
      check({tag, " R7 done seen"}, 32'(done), 32'd1);
      check_mem({tag, " R3 R6 dest bytes"});
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy",  32'(busy), 32'd0);
      check("R1 strobes", 32'({mem_rd, mem_wr, done}), 32'd0);
      check("R1 regs", 32'(x_out | y_out | c_out | 16'(dbank_out)), 32'd0);
      check("R1 addr", 32'(mem_addr), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R4: increment, separate banks
      launch(8'h01, 8'h02, 16'h0040, 16'h0100, 16'd3, 1'b0, 1'b0);
      finish_move("inc");
      check("R4 final x", 32'(x_out), 32'h0044);
      check("R7 idle after done", 32'(busy), 32'd0);

      // R5: decrement, overlapping, destination above source
      launch(8'h03, 8'h03, 16'h0105, 16'h0107, 16'd5, 1'b1, 1'b0);
      finish_move("dec overlap");
      check("R5 final y", 32'(y_out), 32'h0101);

      // R4: increment, overlapping, destination below source
      launch(8'h03, 8'h03, 16'h0205, 16'h0203, 16'd6, 1'b0, 1'b0);
      finish_move("inc overlap");

      // R6: single byte
      launch(8'h01, 8'h02, 16'h0300, 16'h0310, 16'd0, 1'b0, 1'b0);
      finish_move("one byte");
      check("R6 one byte c", 32'(c_out), 32'hFFFF);

      // R4: 16-bit index wrap
      launch(8'h01, 8'h02, 16'hFFFE, 16'h0020, 16'd3, 1'b0, 1'b0);
      finish_move("wrap");
      check("R4 wrapped x", 32'(x_out), 32'h0002);

      // R8: narrow index mode with low-byte wrap
      launch(8'h01, 8'h02, 16'h12F0, 16'h3410, 16'h0014, 1'b0, 1'b1);
      finish_move("idx8");
      check("R8 narrow x", 32'(x_out), 32'h0005);
      check("R8 narrow y", 32'(y_out), 32'h0025);

      // R8 R5: narrow decrement wrap below zero
      launch(8'h01, 8'h02, 16'hAB02, 16'hCD80, 16'd4, 1'b1, 1'b1);
      finish_move("idx8 dec");
      check("R8 narrow dec x", 32'(x_out), 32'h00FD);

      // R9: random stalls
      stall_mode = 1;
      launch(8'h01, 8'h02, 16'h0080, 16'h0180, 16'd20, 1'b0, 1'b0);
      finish_move("stall rand");

      // R9 R10: long stalls, start while busy and start in the done cycle
      stall_mode = 2;
      launch(8'h03, 8'h00, 16'h0010, 16'h0030, 16'd7, 1'b1, 1'b0);
      repeat (9) @(negedge clk);
      src_bank = 8'h02; dst_bank = 8'h01; x_in = 16'h0777; y_in = 16'h0555;
      c_in = 16'd2; dir_dec = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R10 done", 32'(done), 32'd1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 not restarted", 32'(busy), 32'd0);
      check_mem("R10 R9 dest bytes");
      check("R10 c final", 32'(c_out), 32'hFFFF);
      repeat (3) @(negedge clk);
      stall_mode = 0;
      repeat (2) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule